// File: doc/BRIEF.md
# Rank-Switch Bus Turnaround Timer

This block guards the shared data bus of a multi-rank DRAM channel. It remembers the type (read or write) and rank of the last column command that was issued, and counts the cycles since that issue. For the command now presented at its inputs, it works out the gap that command needs and raises `issue_ok` once enough cycles have passed. The command scheduler keeps its candidate on the inputs and issues it on the first cycle where `issue_ok` is high. A command counts as issued on a clock edge where `cmd_valid` and `issue_ok` are both high.

The gap, counted from the previous issue cycle, is the burst length plus the largest extra term that applies. A rank change adds the rank-switch term, and this holds for every pairing of read and write. A write followed by a read adds the write-to-read term. A read followed by a write adds the read-to-write term. When several terms apply, only the largest one is used; the terms are not added together. All four timing values are 8-bit cycle counts. They are loaded through a strobe, and a load is accepted only while the bus is idle.

Top module: `rank_turnaround_timer`

## Requirements
- R1: After reset, and until the first issue, `issue_ok` is 1 whatever type and rank are presented, and `active_rank` reads 0.
- R2: When the next command has the same type and the same rank as the previous one, `issue_ok` first becomes 1 exactly burst cycles after the previous issue cycle.
- R3: A read after a read, or a write after a write, to a different rank first becomes allowed burst + rank-switch cycles after the previous issue.
- R4: A read after a write to the same rank waits burst + write-to-read cycles. A write after a read to the same rank waits burst + read-to-write cycles.
- R5: When both the type and the rank change, the wait is burst plus the larger of the rank-switch term and the applicable direction term, never the sum of the two.
- R6: `active_rank` takes the rank of an issued command on the edge where it issues, and holds its value at every other edge.
- R7: `issue_ok` depends on the presented `cmd_is_wr` (1 = write, 0 = read) and `cmd_rank` whether or not `cmd_valid` is high. A blocked `cmd_valid` changes no state, so the gap is still counted from the last real issue.
- R8: `cfg_load` captures `cfg_burst`, `cfg_wtr`, `cfg_rtw` and `cfg_cs` only when the block is idle. Idle means `cmd_valid` is low and either nothing has issued since reset or at least burst + max(rank-switch, write-to-read, read-to-write) cycles have passed since the last issue. At any other time the load is ignored.
- R9: Reset returns the timing values to burst 4, write-to-read 6, read-to-write 3 and rank-switch 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Candidate command present; it issues when `issue_ok` is also high |
| cmd_is_wr | input | 1 | Candidate type: 1 = write, 0 = read |
| cmd_rank | input | RANK_W | Candidate target rank |
| cfg_load | input | 1 | Request to load new timing values |
| cfg_burst | input | 8 | Burst occupancy in cycles |
| cfg_wtr | input | 8 | Write-to-read extra gap |
| cfg_rtw | input | 8 | Read-to-write extra gap |
| cfg_cs | input | 8 | Rank-switch extra gap |
| issue_ok | output | 1 | Candidate may issue this cycle |
| active_rank | output | RANK_W | Rank of the most recently issued command |

## Verification
The bench measures the first allowed cycle for each of the eight pairings of type and rank change. A design that drops the rank term on a change of direction, or that adds the terms together instead of taking the maximum, shows up as a wait that is off by a whole term. It keeps `cmd_valid` asserted while the command is blocked, so a design that restarts the count or moves `active_rank` on a blocked request misses the expected cycle. It tries a timing load while a burst is still in flight and then checks that the old gaps still apply. After a reset, it checks that the first command is free and that the default timing values are back.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int TT_CNT_W = 8;
  localparam int TT_GAP_W = TT_CNT_W + 1;

  typedef struct packed {
    logic [TT_CNT_W-1:0] burst;
    logic [TT_CNT_W-1:0] wtr;
    logic [TT_CNT_W-1:0] rtw;
    logic [TT_CNT_W-1:0] cs;
  } tt_cfg_t;

  function automatic logic [TT_CNT_W-1:0] tt_max3(input logic [TT_CNT_W-1:0] a,
                                                   input logic [TT_CNT_W-1:0] b,
                                                   input logic [TT_CNT_W-1:0] c);
    logic [TT_CNT_W-1:0] m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
  import tt_pkg::*;
#(
  parameter int DEF_BURST = 4,
  parameter int DEF_WTR   = 6,
  parameter int DEF_RTW   = 3,
  parameter int DEF_CS    = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_en,
  input  tt_cfg_t load_val,
  output tt_cfg_t cfg
);
  tt_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load_en) cfg_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.burst <= TT_CNT_W'(DEF_BURST);
      cfg_q.wtr   <= TT_CNT_W'(DEF_WTR);
      cfg_q.rtw   <= TT_CNT_W'(DEF_RTW);
      cfg_q.cs    <= TT_CNT_W'(DEF_CS);
    end else if (load_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/tt_gap_calc.sv
module tt_gap_calc
  import tt_pkg::*;
#(
  parameter int RANK_W = 2
) (
  input  tt_cfg_t             cfg,
  input  logic [RANK_W-1:0]   prev_rank,
  input  logic                prev_wr,
  input  logic [RANK_W-1:0]   new_rank,
  input  logic                new_wr,
  output logic [TT_GAP_W-1:0] gap,
  output logic [TT_GAP_W-1:0] worst_gap
);
  logic [TT_CNT_W-1:0] add_cs, add_wtr, add_rtw, add_max, all_max;

  always_comb begin
    add_cs  = (prev_rank != new_rank) ? cfg.cs : '0;
    add_wtr = (prev_wr && !new_wr)    ? cfg.wtr : '0;
    add_rtw = (!prev_wr && new_wr)    ? cfg.rtw : '0;
    add_max = tt_max3(add_cs, add_wtr, add_rtw);
    all_max = tt_max3(cfg.cs, cfg.wtr, cfg.rtw);
    gap       = {1'b0, cfg.burst} + {1'b0, add_max};
    worst_gap = {1'b0, cfg.burst} + {1'b0, all_max};
  end
endmodule

// File: rtl/tt_issue_track.sv
module tt_issue_track
  import tt_pkg::*;
#(
  parameter int RANK_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue,
  input  logic [RANK_W-1:0]   cmd_rank,
  input  logic                cmd_wr,
  output logic                prev_valid,
  output logic [RANK_W-1:0]   prev_rank,
  output logic                prev_wr,
  output logic [TT_GAP_W-1:0] elapsed
);
  localparam logic [TT_GAP_W-1:0] ELAPSED_MAX = '1;

  logic                valid_q, valid_d;
  logic [RANK_W-1:0]   rank_q, rank_d;
  logic                wr_q, wr_d;
  logic [TT_GAP_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;

  always_comb begin
    valid_d = valid_q;
    rank_d  = rank_q;
    wr_d    = wr_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (issue) begin
      valid_d = 1'b1;
      rank_d  = cmd_rank;
      wr_d    = cmd_wr;
      cnt_d   = TT_GAP_W'(1);
      cnt_en  = 1'b1;
    end else if (valid_q && cnt_q != ELAPSED_MAX) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rank_q  <= '0;
      wr_q    <= 1'b0;
    end else if (issue) begin
      valid_q <= valid_d;
      rank_q  <= rank_d;
      wr_q    <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign prev_valid = valid_q;
  assign prev_rank  = rank_q;
  assign prev_wr    = wr_q;
  assign elapsed    = cnt_q;
endmodule

// File: rtl/rank_turnaround_timer.sv
module rank_turnaround_timer
  import tt_pkg::*;
#(
  parameter int RANK_W    = 2,
  parameter int DEF_BURST = 4,
  parameter int DEF_WTR   = 6,
  parameter int DEF_RTW   = 3,
  parameter int DEF_CS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_is_wr,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic              cfg_load,
  input  logic [7:0]        cfg_burst,
  input  logic [7:0]        cfg_wtr,
  input  logic [7:0]        cfg_rtw,
  input  logic [7:0]        cfg_cs,
  output logic              issue_ok,
  output logic [RANK_W-1:0] active_rank
);
  tt_cfg_t             cfg, cfg_in;
  logic                prev_valid, prev_wr, issue, idle, load_en;
  logic [RANK_W-1:0]   prev_rank;
  logic [TT_GAP_W-1:0] elapsed, gap, worst_gap;

  assign cfg_in = '{burst: cfg_burst, wtr: cfg_wtr, rtw: cfg_rtw, cs: cfg_cs};

  tt_cfg_regs #(
    .DEF_BURST(DEF_BURST), .DEF_WTR(DEF_WTR), .DEF_RTW(DEF_RTW), .DEF_CS(DEF_CS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(cfg_in), .cfg(cfg)
  );

  tt_gap_calc #(.RANK_W(RANK_W)) u_gap (
    .cfg(cfg), .prev_rank(prev_rank), .prev_wr(prev_wr),
    .new_rank(cmd_rank), .new_wr(cmd_is_wr), .gap(gap), .worst_gap(worst_gap)
  );

  tt_issue_track #(.RANK_W(RANK_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .issue(issue), .cmd_rank(cmd_rank), .cmd_wr(cmd_is_wr),
    .prev_valid(prev_valid), .prev_rank(prev_rank), .prev_wr(prev_wr), .elapsed(elapsed)
  );

  always_comb begin
    issue_ok = !prev_valid || (elapsed >= gap);
    issue    = cmd_valid && issue_ok;
    idle     = !cmd_valid && (!prev_valid || (elapsed >= worst_gap));
    load_en  = cfg_load && idle;
  end

  assign active_rank = prev_rank;
endmodule

// File: rtl/tt_turnaround_chk.sv
module tt_turnaround_chk
  import tt_pkg::*;
#(
  parameter int RANK_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                issue,
  input logic                issue_ok,
  input logic                idle,
  input logic                prev_valid,
  input logic [RANK_W-1:0]   cmd_rank,
  input logic [RANK_W-1:0]   active_rank,
  input logic [TT_GAP_W-1:0] elapsed,
  input tt_cfg_t             cfg
);
  AST_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_valid |-> issue_ok); // R1
  AST_BURST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && prev_valid) |-> (elapsed >= {1'b0, cfg.burst})); // R2
  AST_RANK_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && prev_valid && cmd_rank != active_rank)
      |-> (elapsed >= ({1'b0, cfg.burst} + {1'b0, cfg.cs}))); // R3
  AST_RANK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (active_rank == $past(cmd_rank))); // R6
  AST_RANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(active_rank)); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(cfg)); // R8
endmodule

bind rank_turnaround_timer tt_turnaround_chk #(.RANK_W(RANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .issue_ok(issue_ok), .idle(idle),
  .prev_valid(prev_valid), .cmd_rank(cmd_rank), .active_rank(active_rank),
  .elapsed(elapsed), .cfg(cfg)
);

// File: tb/sim_rank_turnaround_timer.sv
module sim_rank_turnaround_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_is_wr, cfg_load;
  logic [1:0] cmd_rank;
  logic [7:0] cfg_burst, cfg_wtr, cfg_rtw, cfg_cs;
  logic       issue_ok;
  logic [1:0] active_rank;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rank_turnaround_timer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .cmd_rank(cmd_rank), .cfg_load(cfg_load), .cfg_burst(cfg_burst),
    .cfg_wtr(cfg_wtr), .cfg_rtw(cfg_rtw), .cfg_cs(cfg_cs),
    .issue_ok(issue_ok), .active_rank(active_rank)
  );

  // {prev_wr, prev_rank[1:0], next_wr, next_rank[1:0], gap[7:0]}, default timing
  localparam logic [13:0] VEC_TBL [10] = '{
    {1'b0, 2'd0, 1'b0, 2'd0, 8'd4},   // R2 rd->rd same rank
    {1'b1, 2'd1, 1'b1, 2'd1, 8'd4},   // R2 wr->wr same rank
    {1'b0, 2'd0, 1'b0, 2'd1, 8'd6},   // R3 rd->rd rank change
    {1'b1, 2'd2, 1'b1, 2'd3, 8'd6},   // R3 wr->wr rank change
    {1'b1, 2'd0, 1'b0, 2'd0, 8'd10},  // R4 wr->rd
    {1'b0, 2'd3, 1'b1, 2'd3, 8'd7},   // R4 rd->wr
    {1'b1, 2'd0, 1'b0, 2'd2, 8'd10},  // R5 wr->rd rank change, wtr wins
    {1'b0, 2'd3, 1'b1, 2'd1, 8'd7},   // R5 rd->wr rank change, rtw wins
    {1'b0, 2'd1, 1'b0, 2'd1, 8'd4},   // R2 again
    {1'b1, 2'd3, 1'b0, 2'd1, 8'd10}   // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue prev command, then hold next command valid until allowed; measure wait.
  task automatic run_gap(input bit pwr, input logic [1:0] prk, input bit nwr,
                         input logic [1:0] nrk, input int exp, input string req);
    int k;
    repeat (30) @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = pwr; cmd_rank = prk;
    #1;
    check(issue_ok == 1'b1, {req, " prev issue allowed"}, int'(issue_ok), 1);
    @(negedge clk);
    cmd_is_wr = nwr; cmd_rank = nrk;
    k = 1;
    #1;
    while (!issue_ok && k < 600) begin
      @(negedge clk);
      k++;
      #1;
      check(active_rank == prk, "R7 blocked request leaves active_rank", int'(active_rank), int'(prk));
    end
    check(k == exp, {req, " gap"}, k, exp);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(active_rank == nrk, "R6 active_rank after issue", int'(active_rank), int'(nrk));
  endtask

  task automatic load_cfg(input int b, input int w, input int r, input int c);
    cfg_burst = 8'(b); cfg_wtr = 8'(w); cfg_rtw = 8'(r); cfg_cs = 8'(c);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_is_wr = 1'b1; cmd_rank = 2'd3; cfg_load = 1'b0;
    cfg_burst = '0; cfg_wtr = '0; cfg_rtw = '0; cfg_cs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(issue_ok == 1'b1, "R1 first command free", int'(issue_ok), 1);
    check(active_rank == 2'd0, "R1 active_rank reset", int'(active_rank), 0);
    cmd_is_wr = 1'b0; cmd_rank = 2'd2;
    #1;
    check(issue_ok == 1'b1, "R1 first read free", int'(issue_ok), 1);

    for (int i = 0; i < 10; i++) begin
      run_gap(VEC_TBL[i][13], VEC_TBL[i][12:11], VEC_TBL[i][10], VEC_TBL[i][9:8],
              int'(VEC_TBL[i][7:0]), $sformatf("R2-R5 vector %0d", i));
    end

    // R8 load attempted while a burst is in flight: ignored
    repeat (30) @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = 1'b0; cmd_rank = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    load_cfg(20, 20, 20, 20);
    run_gap(1'b0, 2'd0, 1'b0, 2'd1, 6, "R8 busy load ignored");

    // R8 load while idle: accepted (burst 2, wtr 1, rtw 7, cs 5)
    repeat (30) @(negedge clk);
    load_cfg(2, 1, 7, 5);
    run_gap(1'b0, 2'd0, 1'b0, 2'd2, 7, "R8 R3 new cs");
    run_gap(1'b0, 2'd1, 1'b1, 2'd0, 9, "R8 R5 rtw over cs");
    run_gap(1'b1, 2'd1, 1'b0, 2'd3, 7, "R8 R5 cs over wtr");
    run_gap(1'b1, 2'd2, 1'b0, 2'd2, 3, "R8 R4 new wtr");
    run_gap(1'b1, 2'd2, 1'b1, 2'd2, 2, "R8 R2 new burst");

    // R9 reset restores defaults and frees the next command
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = 1'b1; cmd_rank = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_is_wr = 1'b0; cmd_rank = 2'd2;
    rst_n = 1'b0;
    #1;
    check(issue_ok == 1'b1, "R1 free after reset", int'(issue_ok), 1);
    check(active_rank == 2'd0, "R1 active_rank cleared", int'(active_rank), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_gap(1'b1, 2'd0, 1'b0, 2'd1, 10, "R9 default timing restored");
    run_gap(1'b0, 2'd2, 1'b1, 2'd2, 7, "R9 default rtw");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule